// File: doc/BRIEF.md
# Configurable Sum-of-Products Array with Complement Term

This block is the combinational logic plane of a small logic sequencer. It builds its literals from three groups of signals: four dedicated inputs, the values seen on four bidirectional pins, and eight register feedback bits. Each literal comes in true and inverted form. A set of configuration registers, loaded through a plain address/data write port, chooses which literals each product term uses. A second set chooses which product terms feed each OR output. The OR outputs drive the four pin outputs and the J and K inputs of eight sequencer registers.

One extra signal is shared by all terms. A NOR over a chosen subset of the product terms forms a complement term, and any product term may also include that complement term as a literal. This lets the array produce the inverse of a set of terms without spending one term per minterm. Each pin output passes through its own polarity inversion, so a pin can carry either an AND-OR or an AND-NOR function. Each pin also has a dedicated direction term that drives its output enable.

After reset every configuration bit matches an unprogrammed array. All terms read 0, all OR outputs read 0, every pin is an input, and the polarity is non-inverting. All outputs follow the inputs combinationally in the same cycle. Configuration writes take effect from the clock edge that captures them.

Top module: `sop_array`

## Requirements
- R1: A product term is the AND of the literals selected in its 32-bit mask. Bit s (s = 0..15) selects signal s true and bit 16+s selects it inverted. Signals 0..3 are din, 4..7 are bio_in and 8..15 are fb_q. A term with an all-zero mask reads 1.
- R2: A term whose mask selects both the true and the inverted form of the same signal always reads 0.
- R3: The complement term is the NOR of the raw terms flagged in the complement-source word. A logic term whose complement-use bit is set is additionally ANDed with the complement term.
- R4: Each pin OR, J output and K output is the OR of the terms selected in its 32-bit select word; a term that is not selected contributes 0.
- R5: bio_out[p] is the pin-p OR XORed with polarity bit p, so a polarity of 1 turns AND-OR into AND-NOR.
- R6: bio_oe[p] is the pin-p direction term. That term uses its own literal mask and, if direction complement bit p is set, is also ANDed with the complement term. While it is 0 the pin is an input.
- R7: After reset all masks and select words are all ones and polarity is 0. As a result, every output (bio_out, bio_oe, j_out, k_out) is 0 for any input until the first write.
- R8: Writes are captured at the clock edge when cfg_we is high. The address map is:
  - 0..31: term masks
  - 32..35: direction masks
  - 36: complement-use bits per term
  - 37: complement-source bits per term
  - 38..41: pin OR selects
  - 42..49: J selects
  - 50..57: K selects
  - 58: polarity in bits 3:0 and direction complement bits in 7:4

  Writes to 59..63, and any write while reset is asserted, change nothing.
- R9: All outputs respond to changes on din, bio_in and fb_q within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset to unprogrammed state |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| din | input | 4 | Dedicated input lines |
| bio_in | input | 4 | Values present on the bidirectional pins |
| fb_q | input | 8 | Register feedback bits |
| bio_out | output | 4 | Pin output values after polarity |
| bio_oe | output | 4 | Pin output enables (1 = drive) |
| j_out | output | 8 | J inputs for the eight registers |
| k_out | output | 8 | K inputs for the eight registers |

## Verification
Some rules are checked on every cycle:
- Unprogrammed outputs stay quiet.
- A term or direction term with contradictory literals never fires.
- With no term active, the OR outputs are 0 and the pins show only their polarity.
- A polarity write lands in the next cycle.

Other properties can only be shown by the directed scenarios and the reference-model comparison:
- The exact function of a selected literal mix.
- The complement term inverting its sources.
- OR fan-in across several terms.
- Ignored writes to unmapped addresses or during reset.
- Same-cycle combinational response.

// File: rtl/sop_pkg.sv
// Shared definitions for the sum-of-products array: default geometry and
// the configuration address map. Assumes the map is laid out in the order
// of sop_seg_e with one word per item.
package sop_pkg;

    localparam int SOP_DIN_DEF   = 4;
    localparam int SOP_BIO_DEF   = 4;
    localparam int SOP_FB_DEF    = 8;
    localparam int SOP_TERMS_DEF = 32;

    typedef enum int {
        SEG_LIT, SEG_DIR, SEG_CAE, SEG_CAS, SEG_OR, SEG_J, SEG_K, SEG_POL, SEG_END
    } sop_seg_e;

    // Base address of a configuration segment for the given geometry.
    function automatic int sop_seg_base(sop_seg_e seg, int n_terms, int n_bio, int n_fb);
        int base;
        base = 0;
        if (seg == SEG_LIT) return base;
        base += n_terms;
        if (seg == SEG_DIR) return base;
        base += n_bio;
        if (seg == SEG_CAE) return base;
        base += 1;
        if (seg == SEG_CAS) return base;
        base += 1;
        if (seg == SEG_OR) return base;
        base += n_bio;
        if (seg == SEG_J) return base;
        base += n_fb;
        if (seg == SEG_K) return base;
        base += n_fb;
        if (seg == SEG_POL) return base;
        base += 1;
        return base;
    endfunction

endpackage

// File: rtl/sop_term.sv
// One product term: ANDs every literal whose mask bit is set. Assumes the
// literal vector holds true forms in the low half and inverted forms in the
// high half; an empty mask yields 1, a contradictory mask yields 0.
module sop_term #(
    parameter int LIT_W = 32
) (
    input  logic [LIT_W-1:0] lits,
    input  logic [LIT_W-1:0] mask,
    output logic             raw
);

    // Unselected literals are forced to 1 so they do not affect the AND.
    assign raw = &(lits | ~mask);

endmodule

// File: rtl/sop_or_plane.sv
// OR plane: each output is the OR of the terms enabled in its select word.
// Assumes terms arrive already qualified by the complement term.
module sop_or_plane #(
    parameter int N_TERMS = 32,
    parameter int N_OUT   = 4
) (
    input  logic [N_TERMS-1:0] terms,
    input  logic [N_TERMS-1:0] sel [N_OUT],
    output logic [N_OUT-1:0]   y
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Unselected terms contribute 0 to the OR.
        assign y[o] = |(terms & sel[o]);
    end

endmodule

// File: rtl/sop_cfg_regs.sv
// Configuration storage for the array. Every word resets to the
// unprogrammed value (masks and selects all ones, polarity 0). Writes land
// on the clock edge when cfg_we is high; unmapped addresses are ignored.
// Assumes CFG_W covers the literal count, the term count and 2*N_BIO.
module sop_cfg_regs
    import sop_pkg::*;
#(
    parameter int N_BIO   = 4,
    parameter int N_FB    = 8,
    parameter int N_TERMS = 32,
    parameter int LIT_W   = 32,
    parameter int CFG_W   = 32,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [LIT_W-1:0]   lit_mask [N_TERMS],
    output logic [LIT_W-1:0]   dir_mask [N_BIO],
    output logic [N_TERMS-1:0] ca_use,
    output logic [N_TERMS-1:0] ca_src,
    output logic [N_TERMS-1:0] pin_sel [N_BIO],
    output logic [N_TERMS-1:0] j_sel [N_FB],
    output logic [N_TERMS-1:0] k_sel [N_FB],
    output logic [N_BIO-1:0]   pol_q,
    output logic [N_BIO-1:0]   dir_ca
);

    localparam int A_LIT = sop_seg_base(SEG_LIT, N_TERMS, N_BIO, N_FB);
    localparam int A_DIR = sop_seg_base(SEG_DIR, N_TERMS, N_BIO, N_FB);
    localparam int A_CAE = sop_seg_base(SEG_CAE, N_TERMS, N_BIO, N_FB);
    localparam int A_CAS = sop_seg_base(SEG_CAS, N_TERMS, N_BIO, N_FB);
    localparam int A_OR  = sop_seg_base(SEG_OR,  N_TERMS, N_BIO, N_FB);
    localparam int A_J   = sop_seg_base(SEG_J,   N_TERMS, N_BIO, N_FB);
    localparam int A_K   = sop_seg_base(SEG_K,   N_TERMS, N_BIO, N_FB);
    localparam int A_POL = sop_seg_base(SEG_POL, N_TERMS, N_BIO, N_FB);

    for (genvar t = 0; t < N_TERMS; t++) begin : g_lit
        // Literal mask of logic term t.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        lit_mask[t] <= '1;
            else if (cfg_we && cfg_addr == ADDR_W'(A_LIT + t)) lit_mask[t] <= cfg_wdata[LIT_W-1:0];
        end
    end

    for (genvar p = 0; p < N_BIO; p++) begin : g_pin
        // Literal mask of the direction term of pin p.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        dir_mask[p] <= '1;
            else if (cfg_we && cfg_addr == ADDR_W'(A_DIR + p)) dir_mask[p] <= cfg_wdata[LIT_W-1:0];
        end
        // OR select word of pin p.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        pin_sel[p] <= '1;
            else if (cfg_we && cfg_addr == ADDR_W'(A_OR + p))  pin_sel[p] <= cfg_wdata[N_TERMS-1:0];
        end
    end

    for (genvar r = 0; r < N_FB; r++) begin : g_reg
        // J select word of register r.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        j_sel[r] <= '1;
            else if (cfg_we && cfg_addr == ADDR_W'(A_J + r))   j_sel[r] <= cfg_wdata[N_TERMS-1:0];
        end
        // K select word of register r.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        k_sel[r] <= '1;
            else if (cfg_we && cfg_addr == ADDR_W'(A_K + r))   k_sel[r] <= cfg_wdata[N_TERMS-1:0];
        end
    end

    // Per-term complement-use and complement-source flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ca_use <= '1;
            ca_src <= '1;
        end else if (cfg_we && cfg_addr == ADDR_W'(A_CAE)) begin
            ca_use <= cfg_wdata[N_TERMS-1:0];
        end else if (cfg_we && cfg_addr == ADDR_W'(A_CAS)) begin
            ca_src <= cfg_wdata[N_TERMS-1:0];
        end
    end

    // Pin polarity and direction complement-use bits share one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            dir_ca <= '1;
        end else if (cfg_we && cfg_addr == ADDR_W'(A_POL)) begin
            pol_q  <= cfg_wdata[N_BIO-1:0];
            dir_ca <= cfg_wdata[2*N_BIO-1:N_BIO];
        end
    end

endmodule

// File: rtl/sop_array.sv
// Top of the configurable sum-of-products array. Builds true/inverted
// literals from din, bio_in and fb_q, evaluates the logic and direction
// terms, forms the complement NOR from unqualified terms (so no
// combinational loop exists), and drives pin, J and K OR outputs.
// Assumes bio_in carries the pad value; output enables are not applied here.
module sop_array
    import sop_pkg::*;
#(
    parameter int  N_DIN   = SOP_DIN_DEF,
    parameter int  N_BIO   = SOP_BIO_DEF,
    parameter int  N_FB    = SOP_FB_DEF,
    parameter int  N_TERMS = SOP_TERMS_DEF,
    localparam int N_SIG   = N_DIN + N_BIO + N_FB,
    localparam int LIT_W   = 2 * N_SIG,
    localparam int CFG_W   = (LIT_W > N_TERMS) ? LIT_W : N_TERMS,
    localparam int N_ADDR  = sop_seg_base(SEG_END, N_TERMS, N_BIO, N_FB),
    localparam int ADDR_W  = $clog2(N_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [N_DIN-1:0]  din,
    input  logic [N_BIO-1:0]  bio_in,
    input  logic [N_FB-1:0]   fb_q,
    output logic [N_BIO-1:0]  bio_out,
    output logic [N_BIO-1:0]  bio_oe,
    output logic [N_FB-1:0]   j_out,
    output logic [N_FB-1:0]   k_out
);

    logic [LIT_W-1:0]   lit_mask [N_TERMS];
    logic [LIT_W-1:0]   dir_mask [N_BIO];
    logic [N_TERMS-1:0] ca_use;
    logic [N_TERMS-1:0] ca_src;
    logic [N_TERMS-1:0] pin_sel [N_BIO];
    logic [N_TERMS-1:0] j_sel [N_FB];
    logic [N_TERMS-1:0] k_sel [N_FB];
    logic [N_BIO-1:0]   pol_q;
    logic [N_BIO-1:0]   dir_ca;

    logic [N_SIG-1:0]   sig;
    logic [LIT_W-1:0]   lits;
    logic [N_TERMS-1:0] raw_term;
    logic [N_TERMS-1:0] term_vec;
    logic [N_BIO-1:0]   dir_raw;
    logic [N_BIO-1:0]   pin_or;
    logic               ca_n;

    sop_cfg_regs #(
        .N_BIO(N_BIO), .N_FB(N_FB), .N_TERMS(N_TERMS),
        .LIT_W(LIT_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lit_mask(lit_mask), .dir_mask(dir_mask),
        .ca_use(ca_use), .ca_src(ca_src), .pin_sel(pin_sel),
        .j_sel(j_sel), .k_sel(k_sel), .pol_q(pol_q), .dir_ca(dir_ca)
    );

    // Literal vector: true forms low, inverted forms high.
    assign sig  = {fb_q, bio_in, din};
    assign lits = {~sig, sig};

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        sop_term #(.LIT_W(LIT_W)) term_i (
            .lits(lits), .mask(lit_mask[t]), .raw(raw_term[t])
        );
    end

    // Complement term: NOR of the flagged unqualified terms.
    assign ca_n = ~|(raw_term & ca_src);

    // Qualify each logic term with the complement term where requested.
    assign term_vec = raw_term & (~ca_use | {N_TERMS{ca_n}});

    for (genvar p = 0; p < N_BIO; p++) begin : g_dir
        sop_term #(.LIT_W(LIT_W)) dir_i (
            .lits(lits), .mask(dir_mask[p]), .raw(dir_raw[p])
        );
    end

    // Direction terms, optionally qualified by the complement term.
    assign bio_oe = dir_raw & (~dir_ca | {N_BIO{ca_n}});

    sop_or_plane #(.N_TERMS(N_TERMS), .N_OUT(N_BIO)) pin_plane_i (
        .terms(term_vec), .sel(pin_sel), .y(pin_or)
    );
    sop_or_plane #(.N_TERMS(N_TERMS), .N_OUT(N_FB)) j_plane_i (
        .terms(term_vec), .sel(j_sel), .y(j_out)
    );
    sop_or_plane #(.N_TERMS(N_TERMS), .N_OUT(N_FB)) k_plane_i (
        .terms(term_vec), .sel(k_sel), .y(k_out)
    );

    // Per-pin polarity inversion.
    assign bio_out = pin_or ^ pol_q;

endmodule

// File: rtl/sop_array_chk.sv
// Property checker for sop_array, bound into every instance. Assumes the
// top exposes term_vec, pol_q, lit_mask and dir_mask by those names.
module sop_array_chk #(
    parameter int N_BIO   = 4,
    parameter int N_FB    = 8,
    parameter int N_TERMS = 32,
    parameter int N_SIG   = 16,
    parameter int LIT_W   = 32,
    parameter int ADDR_W  = 6,
    parameter int A_POL   = 58,
    parameter int N_ADDR  = 59
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [N_BIO-1:0]   pol_wdata,
    input logic [N_BIO-1:0]   bio_out,
    input logic [N_BIO-1:0]   bio_oe,
    input logic [N_FB-1:0]    j_out,
    input logic [N_FB-1:0]    k_out,
    input logic [N_TERMS-1:0] term_vec,
    input logic [N_BIO-1:0]   pol_q,
    input logic [LIT_W-1:0]   lit_mask [N_TERMS],
    input logic [LIT_W-1:0]   dir_mask [N_BIO]
);

    logic fresh;

    // Tracks whether any mapped write has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         fresh <= 1'b1;
        else if (cfg_we && cfg_addr < ADDR_W'(N_ADDR))      fresh <= 1'b0;
    end

    // R7: unprogrammed array keeps every output low.
    p_defaults_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> (bio_oe == '0 && bio_out == '0 && j_out == '0 && k_out == '0));

    // R4 and R5: with no term active, OR outputs are 0 and pins show polarity.
    p_no_term_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (term_vec == '0) |-> (j_out == '0 && k_out == '0 && bio_out == pol_q));

    // R8: a polarity write is visible in the next cycle.
    p_pol_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(A_POL)) |=> (pol_q == $past(pol_wdata)));

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term_chk
        // R2: a contradictory term never fires.
        p_term_no_conflict_r2: assert property (@(posedge clk) disable iff (!rst_n)
            term_vec[t] |-> ((lit_mask[t][N_SIG-1:0] & lit_mask[t][LIT_W-1:N_SIG]) == '0));
    end

    for (genvar p = 0; p < N_BIO; p++) begin : g_dir_chk
        // R6: a contradictory direction term never enables its pin.
        p_oe_no_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
            bio_oe[p] |-> ((dir_mask[p][N_SIG-1:0] & dir_mask[p][LIT_W-1:N_SIG]) == '0));
    end

endmodule

bind sop_array sop_array_chk #(
    .N_BIO(N_BIO), .N_FB(N_FB), .N_TERMS(N_TERMS), .N_SIG(N_SIG),
    .LIT_W(LIT_W), .ADDR_W(ADDR_W),
    .A_POL(sop_pkg::sop_seg_base(sop_pkg::SEG_POL, N_TERMS, N_BIO, N_FB)),
    .N_ADDR(N_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .pol_wdata(cfg_wdata[N_BIO-1:0]), .bio_out(bio_out), .bio_oe(bio_oe),
    .j_out(j_out), .k_out(k_out), .term_vec(term_vec), .pol_q(pol_q),
    .lit_mask(lit_mask), .dir_mask(dir_mask)
);

// File: tb/sop_array_tb_top.sv
// Directed and model-based bench for sop_array with default geometry.
module sop_array_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  din = '0;
    logic [3:0]  bio_in = '0;
    logic [7:0]  fb_q = '0;
    logic [3:0]  bio_out, bio_oe;
    logic [7:0]  j_out, k_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Bench copy of the configuration, kept from what the bench writes.
    logic [31:0] m_lit [32];
    logic [31:0] m_dir [4];
    logic [31:0] m_cae, m_cas;
    logic [31:0] m_or [4];
    logic [31:0] m_j [8];
    logic [31:0] m_k [8];
    logic [3:0]  m_pol, m_dca;

    sop_array dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .din(din), .bio_in(bio_in), .fb_q(fb_q),
        .bio_out(bio_out), .bio_oe(bio_oe), .j_out(j_out), .k_out(k_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic mirror_reset();
        for (int t = 0; t < 32; t++) m_lit[t] = '1;
        for (int p = 0; p < 4; p++) begin m_dir[p] = '1; m_or[p] = '1; end
        for (int r = 0; r < 8; r++) begin m_j[r] = '1; m_k[r] = '1; end
        m_cae = '1; m_cas = '1; m_pol = '0; m_dca = '1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mirror_reset();
    endtask

    // Register write following the address map of R8.
    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 32)       m_lit[addr] = data;
        else if (addr < 36)  m_dir[addr-32] = data;
        else if (addr == 36) m_cae = data;
        else if (addr == 37) m_cas = data;
        else if (addr < 42)  m_or[addr-38] = data;
        else if (addr < 50)  m_j[addr-42] = data;
        else if (addr < 58)  m_k[addr-50] = data;
        else if (addr == 58) begin m_pol = data[3:0]; m_dca = data[7:4]; end
    endtask

    // Reference evaluation from R1..R6: {bio_oe, bio_out, j_out, k_out}.
    function automatic logic [23:0] model(input logic [3:0] d, input logic [3:0] b, input logic [7:0] f);
        logic [15:0] s;
        logic [31:0] l, raw, term;
        logic        ca;
        logic [3:0]  oe, po;
        logic [7:0]  jj, kk;
        s = {f, b, d};
        l = {~s, s};
        for (int t = 0; t < 32; t++) raw[t] = ((l & m_lit[t]) == m_lit[t]);
        ca = ((raw & m_cas) == 0);
        for (int t = 0; t < 32; t++) term[t] = raw[t] & (!m_cae[t] | ca);
        for (int p = 0; p < 4; p++) begin
            po[p] = (|(term & m_or[p])) ^ m_pol[p];
            oe[p] = ((l & m_dir[p]) == m_dir[p]) & (!m_dca[p] | ca);
        end
        for (int r = 0; r < 8; r++) begin
            jj[r] = |(term & m_j[r]);
            kk[r] = |(term & m_k[r]);
        end
        return {oe, po, jj, kk};
    endfunction

    // Drive inputs away from the edge and compare against the model (R9).
    task automatic cmp(input string req, input logic [3:0] d, input logic [3:0] b, input logic [7:0] f);
        logic [23:0] exp, got;
        @(negedge clk);
        din = d; bio_in = b; fb_q = f;
        #1;
        exp = model(d, b, f);
        got = {bio_oe, bio_out, j_out, k_out};
        check(got == exp, req, 32'(got), 32'(exp));
    endtask

    task automatic prog_clean();
        wr(36, '0); wr(37, '0); wr(58, '0);
        for (int p = 0; p < 4; p++) wr(38 + p, '0);
        for (int r = 0; r < 8; r++) begin wr(42 + r, '0); wr(50 + r, '0); end
    endtask

    task automatic t_reset();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            cmp("R7", 4'(i * 5), 4'(15 - i), 8'(i * 37));
            check({bio_oe, bio_out, j_out, k_out} == '0, "R7 all low",
                  32'({bio_oe, bio_out, j_out, k_out}), 32'h0);
        end
    endtask

    task automatic t_literals();
        do_reset(); prog_clean();
        wr(5, '0); wr(42, 32'h1 << 5);
        wr(3, (32'h1 << 2) | (32'h1 << 29)); wr(53, 32'h1 << 3);
        for (int i = 0; i < 4; i++) begin
            logic d2, f5;
            d2 = i[0]; f5 = i[1];
            cmp("R1", {1'b0, d2, 2'b00}, 4'h0, {2'b00, f5, 5'b0});
            check(j_out[0] == 1'b1, "R1 empty mask", 32'(j_out[0]), 32'h1);
            check(k_out[3] == (d2 & ~f5), "R1 literal mix", 32'(k_out[3]), 32'(d2 & ~f5));
        end
    endtask

    task automatic t_conflict();
        do_reset(); prog_clean();
        wr(7, (32'h1 << 5) | (32'h1 << 21)); wr(39, 32'h1 << 7);
        for (int i = 0; i < 2; i++) begin
            cmp("R2", 4'hF, {2'b00, i[0], 1'b0}, 8'hFF);
            check(bio_out[1] == 1'b0, "R2 contradiction", 32'(bio_out[1]), 32'h0);
        end
    endtask

    task automatic t_ca();
        do_reset(); prog_clean();
        wr(0, 32'h1); wr(1, '0); wr(37, 32'h1); wr(36, 32'h2); wr(38, 32'h2);
        for (int i = 0; i < 2; i++) begin
            cmp("R3", {3'b000, i[0]}, 4'h0, 8'h00);
            check(bio_out[0] == !i[0], "R3 complement", 32'(bio_out[0]), 32'(!i[0]));
        end
        wr(37, '0);
        cmp("R3", 4'h1, 4'h0, 8'h00);
        check(bio_out[0] == 1'b1, "R3 empty source", 32'(bio_out[0]), 32'h1);
    endtask

    task automatic t_pol();
        do_reset(); prog_clean();
        wr(58, 32'hA);
        cmp("R5", 4'h3, 4'h5, 8'h11);
        check(bio_out == 4'hA, "R5 idle polarity", 32'(bio_out), 32'hA);
        wr(2, '0); wr(41, 32'h4);
        cmp("R5", 4'h3, 4'h5, 8'h11);
        check(bio_out == 4'h2, "R5 and-nor", 32'(bio_out), 32'h2);
    endtask

    task automatic t_dir();
        do_reset(); prog_clean();
        wr(34, 32'h1);
        for (int i = 0; i < 2; i++) begin
            cmp("R6", {3'b000, i[0]}, 4'h0, 8'h00);
            check(bio_oe == {1'b0, i[0], 2'b00}, "R6 direction", 32'(bio_oe), 32'({1'b0, i[0], 2'b00}));
        end
    endtask

    task automatic t_or();
        do_reset(); prog_clean();
        wr(8, 32'h1 << 1); wr(9, 32'h1 << 8);
        wr(49, (32'h1 << 8) | (32'h1 << 9)); wr(50, 32'h1 << 9);
        for (int i = 0; i < 4; i++) begin
            cmp("R4", {2'b00, i[0], 1'b0}, 4'h0, {7'b0, i[1]});
            check(j_out[7] == (i[0] | i[1]), "R4 or fan-in", 32'(j_out[7]), 32'(i[0] | i[1]));
            check(k_out[0] == i[1], "R4 unselected", 32'(k_out[0]), 32'(i[1]));
        end
    endtask

    task automatic t_ignored();
        wr(59, '1); wr(63, '1);
        cmp("R8 unmapped", 4'h2, 4'h0, 8'h01);
        cmp("R8 unmapped", 4'h0, 4'hF, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_we = 1'b1; cfg_addr = 6'd58; cfg_wdata = 32'hF;
        @(negedge clk);
        cfg_we = 1'b0; rst_n = 1'b1;
        mirror_reset();
        cmp("R8 write in reset", 4'h0, 4'h0, 8'h00);
        check(bio_out == 4'h0, "R8 write in reset", 32'(bio_out), 32'h0);
    endtask

    task automatic t_random();
        for (int c = 0; c < 8; c++) begin
            do_reset();
            for (int t = 0; t < 32; t++) wr(t, $urandom & $urandom & $urandom);
            for (int p = 0; p < 4; p++) begin
                wr(32 + p, $urandom & $urandom & $urandom);
                wr(38 + p, $urandom);
            end
            for (int r = 0; r < 8; r++) begin wr(42 + r, $urandom); wr(50 + r, $urandom); end
            wr(36, $urandom & $urandom); wr(37, $urandom & $urandom & $urandom);
            wr(58, $urandom & 32'hFF);
            for (int v = 0; v < 16; v++)
                cmp("R9 model", 4'($urandom), 4'($urandom), 8'($urandom));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        mirror_reset();
        t_reset();
        t_literals();
        t_conflict();
        t_ca();
        t_pol();
        t_dir();
        t_or();
        t_ignored();
        t_random();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog got=%h exp=%h", 32'h1, 32'h0);
        finish_run();
    end

endmodule